// File: doc/BRIEF.md
# Asynchronous Burst ROM Read Controller

This block sits on the bus-master side of an external memory port and reads from a page-mode or burst-mode ROM. It takes one request at a time: a start address, an access size (byte, halfword, word or a 16-byte line), a read/write flag, the external bus width (8, 16 or 32 bits), a grouping mode bit and a 4-bit wait setting. It drives the memory address, an active-low chip select, read strobe, write strobe and bus-start strobe, and it samples the memory data bus and an external wait input.

A line read runs as one or more page bursts. Within a burst the read strobe stays low and only the address moves, one bus width per beat, with the address register updating on the falling clock edge. The first beat of each burst takes the full 4-bit wait count and may be stretched by the external wait input. The later beats take only the low two bits of that count and ignore the external wait input. With the grouping mode bit set on narrow buses, the line is cut into 4-byte bursts separated by an idle clock. Sub-line requests and all writes never burst: each bus access is a stand-alone access with the full wait count. Read bytes are packed little-endian into a 128-bit line and returned with a one-clock done pulse.

Top module: `brom_burst_ctrl`

## Requirements
- R1: After reset mem_cs_n, mem_rd_n, mem_we_n and mem_bs_n are high, rsp_done is low and req_ready is high.
- R2: The first beat of every burst lasts 1 + req_wait clock cycles when mem_wait is low; the data on mem_rdata is taken at the end of its last cycle.
- R3: Each later beat of a burst lasts 1 + req_wait[1:0] clock cycles.
- R4: Within a burst mem_cs_n and mem_rd_n stay low between beats and mem_addr advances by the beat size (bus width in bytes, capped at the access size); mem_addr changes on the falling clock edge, so it still shows the previous value just after the rising edge that starts a beat.
- R5: mem_bs_n is low for exactly the first clock cycle of each burst and never elsewhere.
- R6: While mem_wait is high in the last cycle of a first beat the beat is extended; mem_wait has no effect on later beats of a burst.
- R7: req_size encoding 0=1 byte, 1=2 bytes, 2=4 bytes, 3=16-byte line; req_width encoding 0=8-bit, 1=16-bit, 2 or 3=32-bit. A line read gives 16 beats in one burst on an 8-bit bus (4 bursts of 4 with req_group=1), 8 beats in one burst on a 16-bit bus (4 bursts of 2 with req_group=1), and one 4-beat burst on a 32-bit bus regardless of req_group.
- R8: Between two bursts of one request mem_cs_n and mem_rd_n are high for exactly one clock; the next burst restarts with the full wait count and the bus-start strobe.
- R9: A read smaller than a line uses size/width separate single-beat accesses (at least one), each with the full wait count, the bus-start strobe and a one-clock idle gap between them.
- R10: Writes never burst: each beat is a single access with mem_we_n low and mem_rd_n high, and mem_wdata lane k carries request data byte (beat offset + k).
- R11: Byte i of the request lands in rsp_data[8i+7:8i] (little-endian); unread bytes are zero; rsp_done is high for one clock, in the cycle after the final beat's last cycle.
- R12: req_valid is ignored while req_ready is low: no extra access appears on the memory port and the pending result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | External bus width code |
| req_group | input | 1 | Split narrow-bus line reads into 4-byte bursts |
| req_wait | input | WAIT_W | First-access wait count; low bits give the later-beat count |
| req_wdata | input | 8*LINE_BYTES | Write data, byte i at bits 8i+7:8i |
| mem_addr | output | ADDR_W | Memory address, updated on the falling edge |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_bs_n | output | 1 | Bus-start strobe, active low |
| mem_wdata | output | 8*BUS_BYTES | Write data lanes |
| mem_rdata | input | 8*BUS_BYTES | Read data lanes |
| mem_wait | input | 1 | External wait request, active high |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_data | output | 8*LINE_BYTES | Packed read result |

## Verification
The assertions take for granted that requests start at addresses aligned to the access size and bus width, that mem_wait is a clean synchronous level, and that mem_wait is not held high forever in a first beat. The stimulus uses aligned addresses only, raises mem_wait through a bounded window counted from the accepting edge, and holds it high through later beats only on a 32-bit line read, whose single burst never revisits a first beat. Requests are issued only when req_ready is high, except in the one case that deliberately pulses req_valid during a busy transfer.

// File: rtl/brom_pkg.sv
// Shared encodings for the burst ROM controller.
// Assumes: request codes as listed in the brief.
package brom_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_NEXT  = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/brom_beat_plan.sv
// Beat planner: from size, bus width, direction and grouping mode it derives
// the bytes moved per beat, the beats in the request and the beats per burst.
// Assumes: combinational use only at request acceptance.
module brom_beat_plan #(
    parameter int LINE_BYTES  = 16,
    parameter int BUS_BYTES   = 4,
    parameter int GROUP_BYTES = 4,
    parameter int CNT_W       = $clog2(LINE_BYTES) + 1,
    parameter int BB_W        = $clog2(BUS_BYTES) + 1
) (
    input  logic [1:0]       size,
    input  logic [1:0]       width,
    input  logic             write,
    input  logic             group_mode,
    output logic [BB_W-1:0]  beat_bytes,
    output logic [CNT_W-1:0] total_beats,
    output logic [CNT_W-1:0] burst_beats
);
    import brom_pkg::*;

    int unsigned wb, sb, bb, tot, bur;

    // Derive beat geometry (R7, R9, R10)
    always_comb begin
        case (width)
            2'd0:    wb = 1;
            2'd1:    wb = 2;
            default: wb = BUS_BYTES;
        endcase
        case (acc_size_e'(size))
            SZ_BYTE: sb = 1;
            SZ_HALF: sb = 2;
            SZ_WORD: sb = 4;
            default: sb = LINE_BYTES;
        endcase
        bb  = (sb < wb) ? sb : wb;
        tot = sb / bb;
        if (write || acc_size_e'(size) != SZ_LINE) bur = 1;
        else if (wb >= BUS_BYTES)                  bur = tot;
        else if (group_mode)                       bur = GROUP_BYTES / wb;
        else                                       bur = tot;
        beat_bytes  = BB_W'(bb);
        total_beats = CNT_W'(tot);
        burst_beats = CNT_W'(bur);
    end

endmodule

// File: rtl/brom_wait_ctr.sv
// Wait-state down-counter: loaded at the start of each beat, counts to zero.
// Assumes: the sequencer loads it before every beat and enables it while active.
module brom_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              count_en,
    output logic              zero
);
    logic [WAIT_W-1:0] cnt;

    // Load or decrement the remaining wait cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (load)                  cnt <= load_val;
        else if (count_en && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/brom_line_pack.sv
// Line assembler: drops the low lanes of each captured beat into the line
// buffer at a byte offset, little-endian.
// Assumes: offset + count never exceeds LINE_BYTES.
module brom_line_pack #(
    parameter int LINE_BYTES = 16,
    parameter int BUS_BYTES  = 4,
    parameter int CNT_W      = $clog2(LINE_BYTES) + 1,
    parameter int BB_W       = $clog2(BUS_BYTES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    capture,
    input  logic [CNT_W-1:0]        base,
    input  logic [BB_W-1:0]         count,
    input  logic [8*BUS_BYTES-1:0]  lanes,
    output logic [8*LINE_BYTES-1:0] line
);
    localparam int LANE_IW = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        logic [CNT_W-1:0]   off;
        logic [LANE_IW-1:0] lane;
        logic               hit;
        assign off  = CNT_W'(b) - base;
        assign lane = off[LANE_IW-1:0];
        assign hit  = (CNT_W'(b) >= base) && (off < CNT_W'(count));

        // Hold or update one byte of the result line (R11)
        always_ff @(posedge clk) begin
            if (!rst_n)              line[8*b +: 8] <= '0;
            else if (clear)          line[8*b +: 8] <= '0;
            else if (capture && hit) line[8*b +: 8] <= lanes[8*lane +: 8];
        end
    end

endmodule

// File: rtl/brom_burst_ctrl.sv
// Burst ROM controller top: accepts one request, sequences first and later
// beats with their wait counts, strobes, address stepping and line packing.
// Assumes: addresses aligned to size and width; one request in flight.
module brom_burst_ctrl #(
    parameter int ADDR_W       = 32,
    parameter int BUS_BYTES    = 4,
    parameter int LINE_BYTES   = 16,
    parameter int WAIT_W       = 4,
    parameter int LATER_WAIT_W = 2,
    parameter int GROUP_BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic                    req_write,
    input  logic [1:0]              req_width,
    input  logic                    req_group,
    input  logic [WAIT_W-1:0]       req_wait,
    input  logic [8*LINE_BYTES-1:0] req_wdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_cs_n,
    output logic                    mem_rd_n,
    output logic                    mem_we_n,
    output logic                    mem_bs_n,
    output logic [8*BUS_BYTES-1:0]  mem_wdata,
    input  logic [8*BUS_BYTES-1:0]  mem_rdata,
    input  logic                    mem_wait,
    output logic                    rsp_done,
    output logic [8*LINE_BYTES-1:0] rsp_data
);
    import brom_pkg::*;

    localparam int CNT_W    = $clog2(LINE_BYTES) + 1;
    localparam int BB_W     = $clog2(BUS_BYTES) + 1;
    localparam int LINE_BIT = 8 * LINE_BYTES;
    localparam int BUS_BIT  = 8 * BUS_BYTES;

    seq_state_e         st;
    logic               first_cyc, done_q;
    logic               r_wr;
    logic [WAIT_W-1:0]  r_wait;
    logic [BB_W-1:0]    r_bb, p_bb;
    logic [CNT_W-1:0]   r_total, r_bpb, p_total, p_bpb;
    logic [CNT_W-1:0]   r_beat, r_inb, r_off;
    logic [ADDR_W-1:0]  beat_addr;
    logic [LINE_BIT-1:0] r_wdata;
    logic               accept, active, cap, last_beat, burst_end;
    logic               cnt_load, cnt_zero;
    logic [WAIT_W-1:0]  cnt_val;

    brom_beat_plan #(
        .LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES),
        .GROUP_BYTES(GROUP_BYTES), .CNT_W(CNT_W), .BB_W(BB_W)
    ) u_plan (
        .size(req_size), .width(req_width), .write(req_write),
        .group_mode(req_group), .beat_bytes(p_bb),
        .total_beats(p_total), .burst_beats(p_bpb)
    );

    assign accept    = (st == ST_IDLE) && req_valid;
    assign active    = (st == ST_FIRST) || (st == ST_NEXT);
    // R6: external wait only gates the end of a first beat
    assign cap       = ((st == ST_FIRST) && cnt_zero && !mem_wait) ||
                       ((st == ST_NEXT) && cnt_zero);
    assign last_beat = (r_beat == r_total - 1'b1);
    assign burst_end = (r_inb == r_bpb - 1'b1);

    // Pick the wait count for the beat about to start (R2, R3, R8)
    always_comb begin
        cnt_load = accept || (st == ST_GAP) || (cap && !last_beat && !burst_end);
        if (accept)             cnt_val = req_wait;
        else if (st == ST_GAP)  cnt_val = r_wait;
        else                    cnt_val = WAIT_W'(r_wait[LATER_WAIT_W-1:0]);
    end

    brom_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .count_en(active), .zero(cnt_zero)
    );

    // Sequence beats and bursts, step the beat address and offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            first_cyc <= 1'b0;
            done_q    <= 1'b0;
            r_wr      <= 1'b0;
            r_wait    <= '0;
            r_bb      <= '0;
            r_total   <= '0;
            r_bpb     <= '0;
            r_beat    <= '0;
            r_inb     <= '0;
            r_off     <= '0;
            beat_addr <= '0;
            r_wdata   <= '0;
        end else begin
            done_q    <= 1'b0;
            first_cyc <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    r_wr      <= req_write;
                    r_wait    <= req_wait;
                    r_bb      <= p_bb;
                    r_total   <= p_total;
                    r_bpb     <= p_bpb;
                    r_beat    <= '0;
                    r_inb     <= '0;
                    r_off     <= '0;
                    beat_addr <= req_addr;
                    r_wdata   <= req_wdata;
                    first_cyc <= 1'b1;
                    st        <= ST_FIRST;
                end
                ST_FIRST, ST_NEXT: if (cap) begin
                    r_beat    <= r_beat + 1'b1;
                    r_off     <= r_off + CNT_W'(r_bb);
                    beat_addr <= beat_addr + ADDR_W'(r_bb);
                    if (last_beat) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else if (burst_end) begin
                        r_inb <= '0;
                        st    <= ST_GAP;
                    end else begin
                        r_inb <= r_inb + 1'b1;
                        st    <= ST_NEXT;
                    end
                end
                default: begin
                    first_cyc <= 1'b1;
                    st        <= ST_FIRST;
                end
            endcase
        end
    end

    // R4: drive the address out on the falling edge of the bus clock
    always_ff @(negedge clk) begin
        if (!rst_n) mem_addr <= '0;
        else        mem_addr <= beat_addr;
    end

    brom_line_pack #(
        .LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES),
        .CNT_W(CNT_W), .BB_W(BB_W)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(accept), .capture(cap && !r_wr),
        .base(r_off), .count(r_bb), .lanes(mem_rdata), .line(rsp_data)
    );

    assign req_ready = (st == ST_IDLE);
    assign mem_cs_n  = !active;
    assign mem_rd_n  = !(active && !r_wr);
    assign mem_we_n  = !(active && r_wr);
    assign mem_bs_n  = !first_cyc;
    assign mem_wdata = BUS_BIT'(r_wdata >> {r_off, 3'b000});
    assign rsp_done  = done_q;

endmodule

// File: rtl/brom_burst_ctrl_chk.sv
// Protocol checker for the memory-side strobes and the done pulse.
// Assumes: synchronous active-low reset shared with the controller.
module brom_burst_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_cs_n,
    input logic mem_rd_n,
    input logic mem_we_n,
    input logic mem_bs_n,
    input logic rsp_done
);
    // R5
    bs_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_bs_n |=> mem_bs_n);

    // R5
    bs_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_bs_n |-> !mem_cs_n);

    // R8
    burst_opens_with_bs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> !mem_bs_n);

    // R4
    rd_held_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> (mem_rd_n == $past(mem_rd_n)));

    // R10
    rd_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_we_n));

    // R11
    done_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

bind brom_burst_ctrl brom_burst_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
    .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .rsp_done(rsp_done)
);

// File: tb/brom_burst_ctrl_test.sv
`timescale 1ns/100ps
module brom_burst_ctrl_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic         req_write = 1'b0;
    logic [1:0]   req_width = '0;
    logic         req_group = 1'b0;
    logic [3:0]   req_wait = '0;
    logic [127:0] req_wdata = '0;
    logic [31:0]  mem_addr;
    logic         mem_cs_n, mem_rd_n, mem_we_n, mem_bs_n;
    logic [31:0]  mem_wdata;
    logic [31:0]  mem_rdata;
    logic         mem_wait;
    logic         rsp_done;
    logic [127:0] rsp_data;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    brom_burst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_width(req_width), .req_group(req_group), .req_wait(req_wait),
        .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wait(mem_wait),
        .rsp_done(rsp_done), .rsp_data(rsp_data)
    );

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return a[7:0] * 8'd29 + a[15:8] + 8'h11;
    endfunction

    // Memory model: lane k returns the byte at mem_addr + k
    always_comb begin
        for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = byte_at(mem_addr + 32'(k));
    end

    // Cycle count since the accepting edge drives the wait window
    int tcyc = 1000;
    int wait_n = 0;
    bit wait_late = 1'b0;
    int late_from = 0;
    always @(posedge clk) begin
        if (req_valid && req_ready) tcyc <= 0;
        else                        tcyc <= tcyc + 1;
    end
    assign mem_wait = (tcyc < wait_n) || (wait_late && tcyc >= late_from);

    typedef struct {
        logic [31:0] addr;
        int          len;
        bit          first;
        bit          wr;
        bit          gap;
        bit          last;
        logic [31:0] wd;
        int          bb;
    } beat_t;

    beat_t        beat_q[$];
    logic [127:0] rsp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: queue the expected beats and result, then issue the request
    task automatic do_req(input logic [31:0] a, input int sz, input bit wr,
                          input int wid, input bit grp, input int w,
                          input logic [127:0] wd, input int wn, input bit late,
                          input bit intrude);
        int sb, wb, bb, tb, bpb, flen;
        logic [127:0] line;
        sb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 16;
        wb = (wid == 0) ? 1 : (wid == 1) ? 2 : 4;
        bb = (sb < wb) ? sb : wb;
        tb = sb / bb;
        if (wr || sz != 3) bpb = 1;
        else if (wb == 4)  bpb = tb;
        else if (grp)      bpb = 4 / wb;
        else               bpb = tb;
        flen = ((w > wn) ? w : wn) + 1;
        line = '0;
        for (int j = 0; j < tb; j++) begin
            beat_t bt;
            int inb;
            inb      = j % bpb;
            bt.addr  = a + 32'(j * bb);
            bt.first = (inb == 0);
            bt.len   = (j == 0) ? flen : (inb == 0) ? w + 1 : (w & 3) + 1;
            bt.wr    = wr;
            bt.gap   = (inb == bpb - 1) && (j != tb - 1);
            bt.last  = (j == tb - 1);
            bt.bb    = bb;
            bt.wd    = 32'(wd >> (8 * j * bb));
            beat_q.push_back(bt);
        end
        if (!wr)
            for (int i = 0; i < tb * bb; i++) line[8*i +: 8] = byte_at(a + 32'(i));
        rsp_q.push_back(line);
        wait_n    = wn;
        wait_late = late;
        late_from = flen;
        @(negedge clk);
        req_addr  = a;
        req_size  = 2'(sz);
        req_write = wr;
        req_width = 2'(wid);
        req_group = grp;
        req_wait  = 4'(w);
        req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            req_addr  = 32'h0000_9000;
            req_write = 1'b1;
            req_size  = 2'd2;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        wait_late = 1'b0;
        wait_n    = 0;
    endtask

    // Monitor: pops expected beats and results and compares cycle by cycle
    beat_t cur;
    bit    active = 1'b0, exp_gap = 1'b0, exp_done = 1'b0, exp_cont = 1'b0;
    int    cyc = 0;
    logic [31:0] early_addr, prev_addr = '0;
    string bad;
    initial begin
        forever begin
            @(posedge clk);
            #1 early_addr = mem_addr;
            #3;
            if (rst_n) begin
                if (exp_done) begin
                    logic [127:0] e;
                    e = rsp_q.pop_front();
                    check(rsp_done === 1'b1, "R11", "done pulse", 128'(rsp_done), 1);
                    check(rsp_data === e, "R11", "packed data", rsp_data, e);
                    exp_done = 1'b0;
                end else if (rsp_done) begin
                    check(1'b0, "R11", "unexpected done", 1, 0);
                end
                if (exp_gap) begin
                    // R8: one idle clock between bursts
                    check(mem_cs_n && mem_rd_n, "R8", "gap strobes",
                          {mem_cs_n, mem_rd_n}, 2'b11);
                    exp_gap = 1'b0;
                end else begin
                    if (exp_cont) begin
                        check(!mem_cs_n, "R4", "select held between beats", 128'(mem_cs_n), 0);
                        exp_cont = 1'b0;
                    end
                    if (!active && !mem_cs_n) begin
                        if (beat_q.size() == 0) begin
                            check(1'b0, "R12", "access with nothing expected", mem_addr, 0);
                        end else begin
                            cur    = beat_q.pop_front();
                            active = 1'b1;
                            cyc    = 0;
                            bad    = "";
                            if (!cur.first && early_addr !== prev_addr) bad = "R4 early address";
                        end
                    end
                    if (active) begin
                        if (mem_cs_n !== 1'b0 && bad == "") bad = "R2 select";
                        if (mem_addr !== cur.addr && bad == "") bad = cur.first ? "R2 address/length" : "R3 address/length";
                        if ((mem_rd_n !== cur.wr || mem_we_n !== !cur.wr) && bad == "") bad = "R10 strobes";
                        if (mem_bs_n !== !(cur.first && cyc == 0) && bad == "") bad = "R5 bus start";
                        if (cur.wr)
                            for (int k = 0; k < cur.bb; k++)
                                if (mem_wdata[8*k +: 8] !== cur.wd[8*k +: 8] && bad == "") bad = "R10 write lane";
                        cyc++;
                        if (cyc == cur.len) begin
                            check(bad == "", bad, "beat", mem_addr, cur.addr);
                            active    = 1'b0;
                            prev_addr = cur.addr;
                            exp_gap   = cur.gap;
                            exp_done  = cur.last;
                            exp_cont  = !cur.gap && !cur.last;
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: idle state out of reset
        check(mem_cs_n && mem_rd_n && mem_we_n && mem_bs_n && !rsp_done && req_ready,
              "R1", "reset outputs",
              {mem_cs_n, mem_rd_n, mem_we_n, mem_bs_n, rsp_done, req_ready}, 6'b111101);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R3 R4 R7: 8-bit line, one 16-beat burst
        do_req(32'h0000_1000, 3, 0, 0, 0, 5, '0, 0, 0, 0);
        // R7 R8: 8-bit line grouped, 4 bursts of 4
        do_req(32'h0000_2040, 3, 0, 0, 1, 6, '0, 0, 0, 0);
        // R7: 16-bit line, 8 beats
        do_req(32'h0000_3100, 3, 0, 1, 0, 3, '0, 0, 0, 0);
        // R7 R8: 16-bit line grouped, 4 bursts of 2
        do_req(32'h0000_4200, 3, 0, 1, 1, 9, '0, 0, 0, 0);
        // R6 R7: 32-bit line grouped still one burst; wait stretches first beat only
        do_req(32'h0000_5300, 3, 0, 2, 1, 2, '0, 5, 1, 0);
        // R6: wait shorter than the count has no effect
        do_req(32'h0000_5400, 3, 0, 3, 0, 7, '0, 3, 0, 0);
        // R9: byte read on a 32-bit bus
        do_req(32'h0000_6103, 0, 0, 2, 0, 4, '0, 0, 0, 0);
        // R9: word read on an 8-bit bus, four separate accesses
        do_req(32'h0000_7204, 2, 0, 0, 1, 3, '0, 0, 0, 0);
        // R10: halfword write on an 8-bit bus
        do_req(32'h0000_8002, 1, 1, 0, 0, 2, 128'hBEEF, 0, 0, 0);
        // R10: word write on a 32-bit bus, no wait
        do_req(32'h0000_8010, 2, 1, 2, 0, 0, 128'hCAFE_F00D, 0, 0, 0);
        // R10: line write on a 16-bit bus never bursts
        do_req(32'h0000_8100, 3, 1, 1, 0, 1, 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 0, 0, 0);
        // R3: zero wait and a count whose low bits are zero
        do_req(32'h0000_A000, 3, 0, 0, 0, 0, '0, 0, 0, 0);
        do_req(32'h0000_A100, 3, 0, 1, 0, 12, '0, 0, 0, 0);
        // R12: a request pulsed during a busy line read is dropped
        do_req(32'h0000_B000, 3, 0, 0, 0, 2, '0, 0, 0, 1);
        repeat (10) @(negedge clk);
        check(beat_q.size() == 0 && rsp_q.size() == 0, "R12", "scoreboard drained",
              beat_q.size() + rsp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule